// File: doc/BRIEF.md
# Single-Level Page-Table Translation Unit

This block maps a virtual address to a physical address by reading one entry of a single-level page table kept in memory. A request carries the virtual address plus two attributes: whether the access is a write and whether it comes from user mode. The unit splits the address into a virtual page number and a page offset. It adds the page number, scaled by the 4-byte entry size, to a table base register. It then fetches that entry through a memory read port that uses a valid/ready request and a valid response.

The fetched entry is checked for residency and for access rights. A resident entry that permits the access yields the physical page number joined to the unchanged page offset. A non-resident entry yields a page fault. A resident entry whose rights forbid the access yields a protection fault. The unit handles one translation at a time. The table base is loaded through its own write port.

Top module: `xlat_unit`

## Requirements
- R1: The entry read address equals the table base plus the virtual page number (vaddr bits VA_W-1..PG_W) times 4, and is issued once per accepted request.
- R2: Entry format: bit 31 resident, bit 30 supervisor-only, bit 29 readable, bit 28 writable, bits PPN_W-1..0 physical page number. When no fault occurs, the response carries paddr = {page number, vaddr bits PG_W-1..0} and both fault flags low.
- R3: An entry with bit 31 = 0 gives a page fault with paddr 0 and the protection flag low, whatever its permission bits. The two fault flags are never high together.
- R4: A user-mode access to a resident entry with bit 30 = 1 gives a protection fault with paddr 0. A supervisor access to that entry is allowed.
- R5: A write to a resident entry with bit 28 = 0 gives a protection fault. A write needs only bit 28, not bit 29.
- R6: A read from a resident entry with bit 29 = 0 gives a protection fault. A read needs only bit 29, not bit 28.
- R7: At most one translation is in flight. req_ready stays low from acceptance until the response. An entry read request holds its address stable until mem_req_ready.
- R8: Every accepted request produces exactly one response, as a resp_valid pulse lasting one cycle, in the cycle after the entry arrives.
- R9: A base write during a walk does not change that walk's entry address. Later requests use the new base.
- R10: After reset the unit is idle: req_ready high, resp_valid low, mem_req_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Load table base register |
| base_wdata | input | MA_W | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_vaddr | input | VA_W | Virtual address |
| req_is_write | input | 1 | Access is a write |
| req_is_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MA_W | Entry byte address |
| mem_resp_valid | input | 1 | Entry data returned |
| mem_resp_data | input | 32 | Entry contents |
| resp_valid | output | 1 | Result pulse |
| resp_paddr | output | PA_W | Physical address (0 on fault) |
| resp_page_fault | output | 1 | Entry not resident |
| resp_prot_fault | output | 1 | Access rights violated |

## Verification
The assertions check the handshake rules on every cycle. They cover the entry read address staying stable while stalled, req_ready staying low while a read is outstanding, the result lasting exactly one cycle after an entry arrives, faults never being raised together, and a faulting result carrying a zero address. Only the bench scenarios can show that each entry address and result is correct: the bench compares against its own model the arithmetic of base plus scaled page number at the extreme page, the fault priority, each permission rule, and that a base write in mid-walk is ignored.

// File: rtl/xlat_pkg.sv
// Package: shared constants and the walk state type for the translation unit.
// Assumes 32-bit page table entries with the flag bits at the top.
package xlat_pkg;
    localparam int ENTRY_W     = 32;
    localparam int ENTRY_SHIFT = 2;   // 4-byte entries
    localparam int BIT_RES     = 31;
    localparam int BIT_SUP     = 30;
    localparam int BIT_RD      = 29;
    localparam int BIT_WR      = 28;
    localparam int FLAG_LSB    = 28;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/xlat_addr_gen.sv
// Module: splits a virtual address and forms the entry byte address.
// Assumes the scaled page number fits into MA_W bits.
module xlat_addr_gen #(
    parameter int VA_W = 32,
    parameter int PG_W = 12,
    parameter int MA_W = 32
) (
    input  logic [MA_W-1:0] base,
    input  logic [VA_W-1:0] vaddr,
    output logic [MA_W-1:0] entry_addr,
    output logic [PG_W-1:0] offset
);
    import xlat_pkg::*;
    localparam int VPN_W = VA_W - PG_W;
    localparam int SCL_W = VPN_W + ENTRY_SHIFT;

    logic [VPN_W-1:0] vpn;
    logic [SCL_W-1:0] scaled;

    // Split the address and scale the page number to a byte offset in the table.
    always_comb begin
        vpn        = vaddr[VA_W-1:PG_W];
        offset     = vaddr[PG_W-1:0];
        scaled     = {vpn, {ENTRY_SHIFT{1'b0}}};
        entry_addr = base + MA_W'(scaled);
    end
endmodule

// File: rtl/xlat_perm_chk.sv
// Module: decodes a fetched entry and decides fault or physical address.
// Assumes the page number sits in the low PPN_W bits, below the flag field.
module xlat_perm_chk #(
    parameter int PG_W = 12,
    parameter int PA_W = 32
) (
    input  logic [31:0]     entry,
    input  logic            is_write,
    input  logic            is_user,
    input  logic [PG_W-1:0] offset,
    output logic [PA_W-1:0] paddr,
    output logic            page_fault,
    output logic            prot_fault
);
    import xlat_pkg::*;
    localparam int PPN_W = PA_W - PG_W;

    logic deny;

    // Residency first, then supervisor, write and read rights.
    always_comb begin
        deny       = (is_user && entry[BIT_SUP])
                   || (is_write && !entry[BIT_WR])
                   || (!is_write && !entry[BIT_RD]);
        page_fault = !entry[BIT_RES];
        prot_fault = entry[BIT_RES] && deny;
        if (page_fault || prot_fault) paddr = '0;
        else                          paddr = {entry[PPN_W-1:0], offset};
    end

    generate
        if (PPN_W < FLAG_LSB) begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = ^entry[FLAG_LSB-1:PPN_W];
        end
    endgenerate
endmodule

// File: rtl/xlat_ctrl.sv
// Module: walk sequencer - accept, issue entry read, await entry, respond.
// Assumes the memory returns exactly one entry per accepted read.
module xlat_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_req_ready,
    input  logic mem_resp_valid,
    output logic req_ready,
    output logic mem_req_valid,
    output logic accept,
    output logic load_result,
    output logic resp_valid
);
    import xlat_pkg::*;

    walk_state_t state_q, state_d;

    // Decode outputs and next state from the current walk phase.
    always_comb begin
        state_d       = state_q;
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_FETCH);
        resp_valid    = (state_q == ST_RESP);
        accept        = req_ready && req_valid;
        load_result   = (state_q == ST_WAIT) && mem_resp_valid;
        case (state_q)
            ST_IDLE:  if (req_valid)      state_d = ST_FETCH;
            ST_FETCH: if (mem_req_ready)  state_d = ST_WAIT;
            ST_WAIT:  if (mem_resp_valid) state_d = ST_RESP;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Advance the walk phase; reset returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R7: a stalled entry read is not withdrawn
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid);
    // R7: no new request is taken while a read is outstanding
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R8: the result is a single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R8: a result follows the arrival of an entry
    a_r8_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(mem_resp_valid));
endmodule

// File: rtl/xlat_unit.sv
// Module: top of the single-level page-table translation unit.
// Assumes one request at a time and no backpressure on the result.
module xlat_unit #(
    parameter int VA_W = 32,
    parameter int PA_W = 32,
    parameter int PG_W = 12,
    parameter int MA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_we,
    input  logic [MA_W-1:0] base_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_is_write,
    input  logic            req_is_user,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [MA_W-1:0] mem_req_addr,
    input  logic            mem_resp_valid,
    input  logic [31:0]     mem_resp_data,
    output logic            resp_valid,
    output logic [PA_W-1:0] resp_paddr,
    output logic            resp_page_fault,
    output logic            resp_prot_fault
);
    logic [MA_W-1:0] base_q, addr_c, addr_q;
    logic [PG_W-1:0] off_c, off_q;
    logic            wr_q, usr_q, accept, load_result;
    logic [PA_W-1:0] paddr_c, paddr_q;
    logic            pf_c, prf_c, pf_q, prf_q;

    xlat_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
        .req_ready(req_ready), .mem_req_valid(mem_req_valid),
        .accept(accept), .load_result(load_result), .resp_valid(resp_valid)
    );

    xlat_addr_gen #(.VA_W(VA_W), .PG_W(PG_W), .MA_W(MA_W)) u_addr (
        .base(base_q), .vaddr(req_vaddr), .entry_addr(addr_c), .offset(off_c)
    );

    xlat_perm_chk #(.PG_W(PG_W), .PA_W(PA_W)) u_chk (
        .entry(mem_resp_data), .is_write(wr_q), .is_user(usr_q), .offset(off_q),
        .paddr(paddr_c), .page_fault(pf_c), .prot_fault(prf_c)
    );

    // Table base register, loaded through its own write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_wdata;
    end

    // Capture the request and its entry address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0; off_q <= '0; wr_q <= 1'b0; usr_q <= 1'b0;
        end else if (accept) begin
            addr_q <= addr_c; off_q <= off_c;
            wr_q   <= req_is_write; usr_q <= req_is_user;
        end
    end

    // Register the checked result when the entry arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0; pf_q <= 1'b0; prf_q <= 1'b0;
        end else if (load_result) begin
            paddr_q <= paddr_c; pf_q <= pf_c; prf_q <= prf_c;
        end
    end

    assign mem_req_addr    = addr_q;
    assign resp_paddr      = paddr_q;
    assign resp_page_fault = pf_q;
    assign resp_prot_fault = prf_q;

    // R7: entry address is stable while the read stalls
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
    // R3: the two fault kinds never appear together
    a_r3_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_page_fault && resp_prot_fault));
    // R3: a faulting result carries no address
    a_r3_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && (resp_page_fault || resp_prot_fault) |-> resp_paddr == '0);
endmodule

// File: tb/xlat_unit_tb.sv
// Bench: scoreboard with driver, memory model and result monitor.
module xlat_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 32, PA_W = 32, PG_W = 12, MA_W = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic base_we = 1'b0;
    logic [MA_W-1:0] base_wdata = '0;
    logic req_valid = 1'b0, req_is_write = 1'b0, req_is_user = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_ready, mem_req_valid, resp_valid, resp_page_fault, resp_prot_fault;
    logic mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
    logic [MA_W-1:0] mem_req_addr;
    logic [31:0] mem_resp_data = '0;
    logic [PA_W-1:0] resp_paddr;

    int checks = 0, fails = 0;
    logic [31:0] cur_base = '0;
    logic [31:0] exp_addr_q[$];
    logic [31:0] pte_q[$];
    logic [33:0] exp_res_q[$];   // {page_fault, prot_fault, paddr}
    logic [31:0] vec_name_q[$];

    xlat_unit #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .MA_W(MA_W)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [33:0] model(logic [31:0] va, logic wr, logic usr, logic [31:0] pte);
        if (!pte[31]) return {2'b10, 32'h0};                            // R3
        if ((usr && pte[30]) || (wr && !pte[28]) || (!wr && !pte[29]))  // R4 R5 R6
            return {2'b01, 32'h0};
        return {2'b00, pte[19:0], va[11:0]};                            // R2
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic write_base(logic [31:0] b);
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
        cur_base = b;
    endtask

    // Driver: pushes expectations, then presents one request.
    task automatic send(logic [31:0] va, logic wr, logic usr, logic [31:0] pte,
                        logic mid_base, logic [31:0] nb);
        exp_addr_q.push_back(cur_base + {va[31:12], 2'b00});   // R1
        pte_q.push_back(pte);
        exp_res_q.push_back(model(va, wr, usr, pte));
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_is_write = wr; req_is_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_base) write_base(nb);                           // R9
    endtask

    // Memory model: varied stall and latency, checks each entry address.
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [31:0] e, d;
                repeat (n % 3) @(negedge clk);
                check("R7 req_ready low during walk", {63'h0, req_ready}, 64'h0);
                if (exp_addr_q.size() == 0) begin
                    check("R1 unexpected entry read", 64'h1, 64'h0);
                    e = '0; d = '0;
                end else begin
                    e = exp_addr_q.pop_front(); d = pte_q.pop_front();
                    check("R1 R9 entry address", {32'h0, mem_req_addr}, {32'h0, e});
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (n % 2) @(negedge clk);
                mem_resp_valid = 1'b1; mem_resp_data = d;
                @(negedge clk);
                mem_resp_valid = 1'b0; mem_resp_data = 32'hDEAD_BEEF;
                n++;
            end
        end
    end

    // Monitor: pops the scoreboard on each result pulse.
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                if (prev) check("R8 pulse longer than one cycle", 64'h1, 64'h0);
                if (exp_res_q.size() == 0) check("R8 extra result", 64'h1, 64'h0);
                else check("R2 R3 R4 R5 R6 result",
                           {30'h0, resp_page_fault, resp_prot_fault, resp_paddr},
                           {30'h0, exp_res_q.pop_front()});
            end
            prev = rst_n && resp_valid;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=all results");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        check("R10 req_ready", {63'h0, req_ready}, 64'h1);
        check("R10 resp_valid", {63'h0, resp_valid}, 64'h0);
        check("R10 mem_req_valid", {63'h0, mem_req_valid}, 64'h0);
        write_base(32'h0001_0000);
        // R2 user read, rights allow
        send(32'h0000_5123, 1'b0, 1'b1, 32'hB00A_BCDE, 1'b0, '0);
        // R2 R1 supervisor write at the last page
        send(32'hFFFF_FFFF, 1'b1, 1'b0, 32'h7000_0000 | 32'h8000_0000 | 32'h000F_FFFF, 1'b0, '0);
        // R3 not resident, all rights set
        send(32'h0000_0ABC, 1'b0, 1'b0, 32'h7001_2345, 1'b0, '0);
        // R3 not resident beats a user/supervisor violation
        send(32'h0001_0ABC, 1'b1, 1'b1, 32'h4001_2345, 1'b0, '0);
        // R4 user touching supervisor-only page
        send(32'h0002_0010, 1'b0, 1'b1, 32'hF000_0011, 1'b0, '0);
        // R4 supervisor touching supervisor-only page is fine
        send(32'h0002_0020, 1'b0, 1'b0, 32'hF000_0011, 1'b0, '0);
        // R5 write without write right
        send(32'h0003_0004, 1'b1, 1'b0, 32'hA000_0022, 1'b0, '0);
        // R5 write with write right, no read right
        send(32'h0003_0008, 1'b1, 1'b1, 32'h9000_0033, 1'b0, '0);
        // R6 read without read right
        send(32'h0004_0FFF, 1'b0, 1'b0, 32'h9000_0044, 1'b0, '0);
        // R6 read with read right, no write right
        send(32'h0004_0000, 1'b0, 1'b1, 32'hA000_0055, 1'b0, '0);
        // R9 base written mid-walk: this walk keeps the old base
        send(32'h0000_1000, 1'b0, 1'b0, 32'hA000_0066, 1'b1, 32'h2000_0000);
        // R9 next request uses the new base; page 0 maps to the base itself
        send(32'h0000_0777, 1'b0, 1'b0, 32'hA000_0077, 1'b0, '0);
        send(32'h0000_0000, 1'b1, 1'b1, 32'hB000_0088, 1'b0, '0);
        for (int i = 0; i < 100 && exp_res_q.size() != 0; i++) @(negedge clk);
        check("R8 all results returned", {32'h0, 32'(exp_res_q.size())}, 64'h0);
        summary();
    end
endmodule